// File: doc/BRIEF.md
# Data-Selected Reload Counter Modulus Controller

This block drives the modulus-select line of an external divide-by-N / divide-by-N+1 prescaler, so that the average divide ratio of a synthesizer loop follows a single serial data bit. A small up-counter runs on the reference clock. When it reaches all ones, it does not wrap to zero. It reloads from a word in which one bit is taken from the data input. The two data values therefore give two cycle lengths. The counter's lowest bit becomes the modulus-select output.

Both reload values are odd, and the terminal count is odd too. Because of this, the output stays high for one extra state on every counter cycle. That extra state sets a fractional duty cycle that depends only on the reload value. A run of identical data bits of any length keeps the same ratio, so the ratio holds down to DC. The data input is taken only at the reload step. A data change partway through a cycle changes only the length of the following cycle.

The reset is synchronous and active low. While it is held, the counter repeatedly loads the reload word selected by the present data input. The reload values, the counter width and the way the data bit is applied are parameters, and elaboration checks them.

Top module: `fsk_modctl`

## Requirements
- R1: Away from the terminal count, the 4-bit counter advances by exactly one on each rising clock edge.
- R2: `carry_out` is high exactly while the count is all ones (15). It is never high on two consecutive cycles, and `mod_ctl` is high whenever it is high.
- R3: On the clock edge that follows a cycle with `carry_out` high, the counter loads 5 if `data_in` is 0 and 7 if `data_in` is 1 (the data bit drives bit 1 of the reload word).
- R4: A counter cycle, counted from the reloaded state through the terminal state, lasts 16 minus the reload value: 11 clocks for data 0 and 9 clocks for data 1.
- R5: `mod_ctl` equals the counter's bit 0. It changes value on every clock, except from the terminal state to the reloaded state, where it stays high.
- R6: Within one cycle, `mod_ctl` is low in (15 − s)/2 states, where s is the reload value: 5 of 11 for data 0 and 4 of 9 for data 1.
- R7: `data_in` is used only on the reload edge. Changing it during a cycle does not alter the length or the low count of that cycle.
- R8: While `rst_n` is low, every clock edge loads the reload value chosen by the current `data_in`. During reset `mod_ctl` is 1 and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 1 | Serial data bit that selects the reload value |
| mod_ctl | output | 1 | Modulus-select bit for the prescaler (counter bit 0) |
| carry_out | output | 1 | High while the count is at its terminal value |

## Verification
The bench first holds data at 0 and then at 1 over many counter cycles. These two runs separate the 11-state and 9-state patterns and their low counts of 5 and 4. It then flips the data exactly at each reload, which shows that back-to-back cycles of different length line up with no lost or extra state. Next it drives random data on every clock. Any sampling of data other than at the reload edge would then show up as a cycle whose length or low count does not match the value present at its start. Two reset runs, one with each data value, confirm that the first cycle after reset starts from the selected reload word.

// File: rtl/fsk_modctl_pkg.sv
package fsk_modctl_pkg;

   // number of set bits in a constant word
   function automatic int unsigned ones_in(input int unsigned v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) begin
         if (v[i]) n++;
      end
      return n;
   endfunction

   // index of the lowest set bit, 0 when none
   function automatic int unsigned lowest_one(input int unsigned v);
      int unsigned p;
      p = 0;
      for (int i = 31; i >= 0; i--) begin
         if (v[i]) p = i;
      end
      return p;
   endfunction

endpackage

// File: rtl/fsk_reload_sel.sv
module fsk_reload_sel
   import fsk_modctl_pkg::*;
#(
   parameter int unsigned W         = 4,
   parameter int unsigned LOAD_ZERO = 5,
   parameter int unsigned LOAD_ONE  = 7
) (
   input  logic         data_bit,
   output logic [W-1:0] load_word
);

   localparam int unsigned DIFF   = LOAD_ZERO ^ LOAD_ONE;
   localparam bit          DIRECT = (ones_in(DIFF) == 1) && ((LOAD_ONE & DIFF) != 0);
   localparam int unsigned POS    = lowest_one(DIFF);
   localparam logic [W-1:0] WORD_ZERO = LOAD_ZERO[W-1:0];
   localparam logic [W-1:0] WORD_ONE  = LOAD_ONE[W-1:0];

   generate
      if (DIRECT) begin : g_direct
         // the data bit wires straight into the one differing load bit
         always_comb begin
            load_word      = WORD_ZERO;
            load_word[POS] = data_bit;
         end
      end else begin : g_mux
         assign load_word = data_bit ? WORD_ONE : WORD_ZERO;
      end
   endgenerate

endmodule

// File: rtl/fsk_cycle_counter.sv
module fsk_cycle_counter #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] load_word,
   output logic [W-1:0] count,
   output logic         term
);

   localparam logic [W-1:0] ONE_STEP = {{(W-1){1'b0}}, 1'b1};

   assign term = &count;

   always_ff @(posedge clk) begin
      if (!rst_n || term) begin
         count <= load_word;
      end else begin
         count <= count + ONE_STEP;
      end
   end

   // R1: plain increment away from terminal count
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> (count == $past(count) + ONE_STEP));

   // R2: terminal count never lasts two cycles
   assert_term_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> !term);

endmodule

// File: rtl/fsk_modctl.sv
module fsk_modctl
   import fsk_modctl_pkg::*;
#(
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned LOAD_ZERO = 5,
   parameter int unsigned LOAD_ONE  = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic data_in,
   output logic mod_ctl,
   output logic carry_out
);

   localparam int unsigned TOP_VAL = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] WORD_ZERO = LOAD_ZERO[CNT_W-1:0];
   localparam logic [CNT_W-1:0] WORD_ONE  = LOAD_ONE[CNT_W-1:0];

   // elaboration checks on the configuration
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("fsk_modctl: CNT_W out of range");
      end
      if ((LOAD_ZERO % 2) == 0 || (LOAD_ONE % 2) == 0) begin : g_bad_parity
         $error("fsk_modctl: reload values must be odd");
      end
      if (LOAD_ZERO >= TOP_VAL || LOAD_ONE >= TOP_VAL) begin : g_bad_range
         $error("fsk_modctl: reload values must be below terminal count");
      end
      if (LOAD_ZERO == LOAD_ONE) begin : g_bad_same
         $error("fsk_modctl: reload values must differ");
      end
   endgenerate

   logic [CNT_W-1:0] load_word;
   logic [CNT_W-1:0] count;
   logic             term;

   fsk_reload_sel #(
      .W         (CNT_W),
      .LOAD_ZERO (LOAD_ZERO),
      .LOAD_ONE  (LOAD_ONE)
   ) u_sel (
      .data_bit  (data_in),
      .load_word (load_word)
   );

   fsk_cycle_counter #(
      .W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_word (load_word),
      .count     (count),
      .term      (term)
   );

   assign mod_ctl   = count[0];
   assign carry_out = term;

   // R3: reload word follows the data value present at the terminal edge
   assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |=> (count == ($past(data_in) ? WORD_ONE : WORD_ZERO)));

   // R2: carry only with the output high
   assert_carry_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> mod_ctl);

   // R5: output toggles except across reload
   assert_mod_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_out |=> (mod_ctl != $past(mod_ctl)));

   // R5: output held high across reload
   assert_mod_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |=> mod_ctl);

   // R8: reset loads the data-selected word
   assert_reset_load_R8: assert property (@(posedge clk)
      !rst_n |=> (count == ($past(data_in) ? WORD_ONE : WORD_ZERO)));

endmodule

// File: tb/tb_fsk_modctl.sv
module tb_fsk_modctl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic data_in = 1'b0;
   logic mod_ctl;
   logic carry_out;

   int checks = 0;
   int errors = 0;
   int len, lows, cur_s;
   logic prev_mod, prev_carry, m, c;

   always #5 clk = ~clk;

   fsk_modctl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_in   (data_in),
      .mod_ctl   (mod_ctl),
      .carry_out (carry_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int reload_of(input logic d);
      return d ? 7 : 5;
   endfunction

   task automatic do_reset(input logic d);
      @(negedge clk);
      rst_n   = 1'b0;
      data_in = d;
      repeat (3) @(negedge clk);
      chk(mod_ctl == 1'b1, "R8 mod_ctl during reset", int'(mod_ctl), 1);
      chk(carry_out == 1'b0, "R8 carry_out during reset", int'(carry_out), 0);
      rst_n      = 1'b1;
      len        = 1;
      lows       = 0;
      prev_mod   = 1'b1;
      prev_carry = 1'b0;
      cur_s      = reload_of(d);
   endtask

   // mode 0: data 0, 1: data 1, 2: flip at each reload, 3: random each clock
   task automatic run(input int mode, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         m = mod_ctl;
         c = carry_out;
         len++;
         if (!m) lows++;
         if (prev_carry)
            chk(m == 1'b1 && prev_mod == 1'b1, "R5 R3 high held across reload", int'(m), 1);
         else
            chk(m != prev_mod, "R1 R5 toggle each clock", int'(m), int'(!prev_mod));
         if (c) begin
            chk(m == 1'b1, "R2 carry with mod_ctl high", int'(m), 1);
            chk(len == 16 - cur_s, "R3 R4 R7 cycle length", len, 16 - cur_s);
            chk(lows == (15 - cur_s) / 2, "R6 R7 low states per cycle", lows, (15 - cur_s) / 2);
            len  = 0;
            lows = 0;
         end else if (len > 16) begin
            chk(1'b0, "R2 terminal count missing", len, 16 - cur_s);
            len  = 0;
            lows = 0;
         end
         prev_mod   = m;
         prev_carry = c;
         case (mode)
            0:       data_in = 1'b0;
            1:       data_in = 1'b1;
            2:       if (c) data_in = ~data_in;
            default: data_in = 1'($urandom % 2);
         endcase
         if (c) cur_s = reload_of(data_in);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset(1'b1);
      run(1, 200);
      run(0, 200);
      run(2, 300);
      run(3, 2000);
      do_reset(1'b0);
      run(3, 1000);
      run(1, 50);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule